// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block sits on the receive side of one twisted-pair port, after the pulse and delimiter recognisers. Each incoming link test pulse and each valid end-of-frame delimiter arrives as a one-cycle event. A second bit with the event tells whether the shape was seen negative, meaning inverted at the raw pins. From these events the block decides whether the pair is wired backwards. It then flips every received data bit on the fly, with no added latency, and it tells the link monitor which link pulses count.

Detection starts armed, after reset and again each time the port drops into link failure. While armed, pulses of either polarity are accepted. A run of `PULSE_VOTES` consecutive pulses of one polarity gives a provisional decision. The first frame that ends with a valid delimiter gives a final decision, which replaces any decision based on pulses alone. Once any decision exists, only pulses that look true after correction pass the qualifier.

Top module: `rx_polarity_corrector`

## Requirements
- R1: A synchronous active-low reset sets `pol_reversed` to 0 and puts detection in the armed state, so that any pulse is accepted on the next cycle.
- R2: While armed, `pulse_ok` equals `pulse_vld` in the same cycle, whatever the value of `pulse_neg`.
- R3: While armed, `PULSE_VOTES` consecutive pulses with the same `pulse_neg` value set `pol_reversed` to that value from the next cycle on. A pulse of the other polarity restarts the run at one. `pol_reversed` never changes unless an event arrived in the cycle before.
- R4: While not locked, a delimiter event sets `pol_reversed` to `etd_neg` and locks the decision from the next cycle on. This holds even if a pulse-based decision already exists. If a pulse completes a run in the same cycle as a delimiter, the delimiter wins.
- R5: Once locked, further delimiters and pulses leave `pol_reversed` unchanged until link failure or reset.
- R6: Once a decision exists (from pulses or from a frame), `pulse_ok` is high only for pulses whose `pulse_neg` equals `pol_reversed`. Other pulses are rejected.
- R7: `rx_fixed` equals `rx_raw` with every bit XORed with `pol_reversed`, in the same cycle.
- R8: A cycle with `link_fail` high re-arms detection from the next cycle on and keeps `pol_reversed`. Any pulse or delimiter in that cycle is ignored for the decision.
- R9: `pol_reversed` is a registered status output holding the current decision (1 means the pair is inverted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_fail | input | 1 | Port is in link failure; re-arms detection |
| pulse_vld | input | 1 | One-cycle link test pulse event |
| pulse_neg | input | 1 | Pulse was seen with negative (inverted) shape |
| etd_vld | input | 1 | One-cycle valid end-of-frame delimiter event |
| etd_neg | input | 1 | Delimiter was seen with negative (inverted) shape |
| rx_raw | input | DATA_W | Received data bits before correction |
| rx_fixed | output | DATA_W | Received data bits after correction |
| pulse_ok | output | 1 | Pulse qualifier for the link monitor |
| pol_reversed | output | 1 | Current polarity decision |

## Verification
Three pairs of events can land in the same cycle:
- A pulse that completes a voting run together with a delimiter.
- Link failure together with both kinds of event.
- A pulse together with a data word, while the decision flips.

The bench drives each pair in one cycle. A behavioural model gives the expected outcome: the delimiter wins, link failure discards both events, and the data uses the flag value from before the edge. The bench compares the qualifier, the flag and the corrected data against this model on every cycle.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

   typedef enum logic [1:0] {
      ST_ARMED  = 2'd0,
      ST_PULSE  = 2'd1,
      ST_LOCKED = 2'd2
   } pol_state_e;

endpackage

// File: rtl/rxpol_vote.sv
module rxpol_vote #(
   parameter int PULSE_VOTES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic pulse_vld,
   input  logic pulse_neg,
   output logic vote_done
);
   localparam int CNT_W = $clog2(PULSE_VOTES + 1);
   localparam logic [CNT_W-1:0] TARGET = CNT_W'(PULSE_VOTES);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             last_q;
   logic             restart;

   always_comb begin
      restart = (cnt_q == '0) || (pulse_neg != last_q);
      if (restart)
         cnt_nxt = CNT_W'(1);
      else if (cnt_q == TARGET)
         cnt_nxt = cnt_q;
      else
         cnt_nxt = cnt_q + CNT_W'(1);
      vote_done = pulse_vld && !clear && (cnt_nxt == TARGET);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q  <= '0;
         last_q <= 1'b0;
      end else if (pulse_vld) begin
         cnt_q  <= cnt_nxt;
         last_q <= pulse_neg;
      end
   end

endmodule

// File: rtl/rxpol_fsm.sv
module rxpol_fsm
   import rxpol_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic link_fail,
   input  logic pulse_vld,
   input  logic pulse_neg,
   input  logic etd_vld,
   input  logic etd_neg,
   input  logic vote_done,
   output logic reversed,
   output logic armed,
   output logic locked,
   output logic pulse_ok
);
   pol_state_e st_q, st_d;
   logic       rev_q, rev_d;

   always_comb begin
      st_d  = st_q;
      rev_d = rev_q;
      if (link_fail) begin
         st_d = ST_ARMED;
      end else if (etd_vld && st_q != ST_LOCKED) begin
         st_d  = ST_LOCKED;
         rev_d = etd_neg;
      end else if (st_q == ST_ARMED && vote_done) begin
         st_d  = ST_PULSE;
         rev_d = pulse_neg;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_ARMED;
         rev_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rev_q <= rev_d;
      end
   end

   assign reversed = rev_q;
   assign armed    = (st_q == ST_ARMED);
   assign locked   = (st_q == ST_LOCKED);
   assign pulse_ok = pulse_vld && (armed || (pulse_neg == rev_q));

endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector #(
   parameter int DATA_W      = 4,
   parameter int PULSE_VOTES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_fail,
   input  logic              pulse_vld,
   input  logic              pulse_neg,
   input  logic              etd_vld,
   input  logic              etd_neg,
   input  logic [DATA_W-1:0] rx_raw,
   output logic [DATA_W-1:0] rx_fixed,
   output logic              pulse_ok,
   output logic              pol_reversed
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (PULSE_VOTES < 1) begin : g_bad_votes
         $error("PULSE_VOTES must be at least 1");
      end
   endgenerate

   logic st_armed, st_locked, vote_done, rev_w;

   rxpol_vote #(.PULSE_VOTES(PULSE_VOTES)) u_vote (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (link_fail || !st_armed),
      .pulse_vld (pulse_vld),
      .pulse_neg (pulse_neg),
      .vote_done (vote_done)
   );

   rxpol_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_fail (link_fail),
      .pulse_vld (pulse_vld),
      .pulse_neg (pulse_neg),
      .etd_vld   (etd_vld),
      .etd_neg   (etd_neg),
      .vote_done (vote_done),
      .reversed  (rev_w),
      .armed     (st_armed),
      .locked    (st_locked),
      .pulse_ok  (pulse_ok)
   );

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      assign rx_fixed[i] = rx_raw[i] ^ rev_w;
   end

   assign pol_reversed = rev_w;

endmodule

// File: rtl/rxpol_checker.sv
module rxpol_checker (
   input logic clk,
   input logic rst_n,
   input logic link_fail,
   input logic pulse_vld,
   input logic pulse_neg,
   input logic etd_vld,
   input logic etd_neg,
   input logic pulse_ok,
   input logic pol_reversed,
   input logic st_armed,
   input logic st_locked
);
   p_reset_clears_r1: assert property (@(posedge clk)
      !rst_n |=> (!pol_reversed && st_armed));

   p_ok_needs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_ok |-> pulse_vld);

   p_armed_accepts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_armed && pulse_vld) |-> pulse_ok);

   p_flip_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(pol_reversed)) |-> $past(pulse_vld || etd_vld));

   p_etd_decides_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (etd_vld && !link_fail && !st_locked) |=> (st_locked && pol_reversed == $past(etd_neg)));

   p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_locked && !link_fail) |=> (st_locked && $stable(pol_reversed)));

   p_true_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_armed && pulse_vld && (pulse_neg != pol_reversed)) |-> !pulse_ok);

   p_fail_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
      link_fail |=> (st_armed && $stable(pol_reversed)));

endmodule

bind rx_polarity_corrector rxpol_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .link_fail    (link_fail),
   .pulse_vld    (pulse_vld),
   .pulse_neg    (pulse_neg),
   .etd_vld      (etd_vld),
   .etd_neg      (etd_neg),
   .pulse_ok     (pulse_ok),
   .pol_reversed (pol_reversed),
   .st_armed     (st_armed),
   .st_locked    (st_locked)
);

// File: tb/tb_rx_polarity_corrector.sv
`timescale 1ns/1ps
module tb_rx_polarity_corrector;
   localparam int W     = 4;
   localparam int VOTES = 3;

   logic clk = 1'b0;
   logic rst_n, link_fail, pulse_vld, pulse_neg, etd_vld, etd_neg;
   logic [W-1:0] rx_raw, rx_fixed;
   logic pulse_ok, pol_reversed;

   int total = 0, bad = 0;
   bit finished = 0;

   // reference model state: 0 armed, 1 decided by pulses, 2 locked by frame
   int m_state = 0, m_cnt = 0;
   bit m_rev = 0, m_last = 0;
   logic [W-1:0] pat = '0;

   always #2 clk = ~clk;

   rx_polarity_corrector #(.DATA_W(W), .PULSE_VOTES(VOTES)) dut (
      .clk(clk), .rst_n(rst_n), .link_fail(link_fail),
      .pulse_vld(pulse_vld), .pulse_neg(pulse_neg),
      .etd_vld(etd_vld), .etd_neg(etd_neg),
      .rx_raw(rx_raw), .rx_fixed(rx_fixed),
      .pulse_ok(pulse_ok), .pol_reversed(pol_reversed));

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit rs, input bit lf, input bit pv, input bit pn,
                       input bit ev, input bit en);
      @(negedge clk);
      rst_n = ~rs; link_fail = lf; pulse_vld = pv; pulse_neg = pn;
      etd_vld = ev; etd_neg = en;
      pat = pat * 5 + 3;
      rx_raw = pat;
      #1;
      check("R9 flag", W'(pol_reversed), W'(m_rev));
      check(m_state == 0 ? "R2 accept" : "R6 qualify", W'(pulse_ok),
            W'(pv && (m_state == 0 || pn == m_rev)));
      check("R7 data", rx_fixed, pat ^ {W{m_rev}});
      @(posedge clk);
      if (rs) begin
         m_state = 0; m_cnt = 0; m_rev = 0; m_last = 0;
      end else if (lf) begin
         m_state = 0; m_cnt = 0;
      end else if (ev && m_state != 2) begin
         m_rev = en; m_state = 2; m_cnt = 0;
      end else if (m_state == 0 && pv) begin
         if (m_cnt == 0 || pn != m_last) m_cnt = 1;
         else m_cnt++;
         m_last = pn;
         if (m_cnt >= VOTES) begin
            m_rev = pn; m_state = 1; m_cnt = 0;
         end
      end
   endtask

   task automatic expect_rev(input string tag, input bit exp);
      #1;
      check(tag, W'(pol_reversed), W'(exp));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      rst_n = 0; link_fail = 0; pulse_vld = 0; pulse_neg = 0;
      etd_vld = 0; etd_neg = 0; rx_raw = '0;
      step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      expect_rev("R1 reset flag", 0);
      step(0, 0, 1, 1, 0, 0);              // R2: negative pulse accepted while armed
      step(0, 0, 1, 0, 0, 0);              // R2/R3: switch restarts run
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 1, 0, 0);
      step(0, 0, 1, 1, 0, 0);
      expect_rev("R3 not yet", 0);
      step(0, 0, 1, 1, 0, 0);
      expect_rev("R3 votes reached", 1);
      step(0, 0, 1, 1, 0, 0);              // R6: true after correction
      step(0, 0, 1, 0, 0, 0);              // R6: rejected
      idle(2);
      step(0, 0, 0, 0, 1, 0);              // R4: frame overrides pulse decision
      expect_rev("R4 frame override", 0);
      step(0, 0, 0, 0, 1, 1);
      expect_rev("R5 locked ignores frame", 0);
      step(0, 0, 1, 1, 0, 0);              // R6 reject while locked
      step(0, 0, 1, 0, 0, 0);
      step(0, 1, 1, 1, 1, 1);              // R8: events during link failure dropped
      expect_rev("R8 flag kept", 0);
      step(0, 0, 1, 1, 0, 0);              // R2 armed again
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 1, 1);              // R4: delimiter beats completing run
      expect_rev("R4 same-cycle delimiter wins", 1);
      step(0, 1, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      expect_rev("R3 relearn after fail", 0);
      step(0, 0, 1, 1, 1, 1);              // R4 from pulse-decided state with pulse
      expect_rev("R4 frame after pulses", 1);
      idle(3);
      step(1, 0, 0, 0, 0, 0);
      expect_rev("R1 reset mid-run", 0);
      step(0, 0, 1, 1, 0, 0);
      idle(2);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule